// File: doc/BRIEF.md
# Stop-mode wakeup clock sequencer

This block decides which clock enables are live while a processor goes into and comes back from a low-power stop mode. A stop request taken in the run state first gates the system and flash clocks. In the next cycle the block settles into stop, where the oscillator and the PLL are each kept running or shut down according to their own configuration bits. An interrupt or debug wakeup then brings the clocks back in a fixed order. The oscillator is brought up first and the block waits for it to report ready. The PLL is brought up next and the block waits for lock. The flash clock then runs alone for a fixed pre-roll, and only after that are the system clocks enabled.

Any wait can be skipped. A clock source that stayed on during stop has no restart wait. A lock-bypass option drops the PLL-lock wait. External-clock mode drops every startup wait. The clock-out pin enable follows the PLL enable, and a disable bit parks the pin low. Configuration arrives through two plain write ports: one for the control bits and one for the oscillator-startup timeout. If the oscillator does not report ready within that timeout, an error flag is raised and the block stays in the oscillator wait.

Top module: `stop_clk_seq`

## Requirements
- R1: After reset the block is in the run state with oscillator, PLL, flash, system and clock-out enables all high and the error flag low. The control bits reset to osc_off=1, pll_off=1, clkout_off=0, skip_lock=0, ext_clk=0, and the timeout resets to TMO_RST.
- R2: A stop request seen in run with no wakeup source active drops the system and flash enables on the next edge while the oscillator and PLL stay on. One edge later the block is in stop with osc_en_o = !osc_off and pll_en_o = !pll_off. The control write bits are: bit0 osc_off, bit1 pll_off, bit2 clkout_off, bit3 skip_lock, bit4 ext_clk.
- R3: A wakeup from stop with osc_off=1 raises osc_en_o on the next edge and holds the block there, with system and flash enables low, until osc_ready_i is high.
- R4: If pll_off=1 and skip_lock=0, the block then raises pll_en_o and waits, system and flash enables still low, until pll_lock_i is high.
- R5: With skip_lock=1 the block goes from oscillator ready straight to the flash pre-roll without waiting for pll_lock_i.
- R6: With ext_clk=1 a wakeup goes straight to the flash pre-roll, ignoring osc_ready_i and pll_lock_i.
- R7: On every wakeup, flash_clk_en_o is high with sys_clk_en_o low for exactly PRE_CYC (16) cycles, after which sys_clk_en_o rises and the block is in run.
- R8: A clock source left running in stop (osc_off=0 or pll_off=0) has no restart wait. With both left on, a wakeup enters the pre-roll on the next edge.
- R9: clkout_en_o is high only while pll_en_o is high, so during stop with pll_off=1 it is low.
- R10: With clkout_off=1, clkout_en_o is low in every state.
- R11: A wakeup that arrives in the entry cycle aborts the entry: the next edge goes to the flash pre-roll with the oscillator and PLL still on.
- R12: irq_wake_i and dbg_wake_i wake the block identically. A stop request is ignored outside run, and it is also ignored in run while a wakeup source is active.
- R13: If osc_ready_i stays low, osc_tmo_err_o rises TMO+1 cycles after the oscillator wait is entered (TMO is the programmed timeout). The block stays in the wait, and the flag clears on the edge that leaves the wait once osc_ready_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Control-bit write strobe |
| cfg_wdata_i | input | 5 | Control bits {ext_clk, skip_lock, clkout_off, pll_off, osc_off} |
| tmo_we_i | input | 1 | Timeout write strobe |
| tmo_wdata_i | input | TMO_W | Oscillator-startup timeout in cycles |
| stop_req_i | input | 1 | Request to enter stop |
| irq_wake_i | input | 1 | Interrupt wakeup source |
| dbg_wake_i | input | 1 | Debug-entry wakeup source (debug port or pin) |
| osc_ready_i | input | 1 | Oscillator reports stable |
| pll_lock_i | input | 1 | PLL reports lock |
| osc_en_o | output | 1 | Oscillator enable |
| pll_en_o | output | 1 | PLL enable |
| flash_clk_en_o | output | 1 | Flash clock enable |
| sys_clk_en_o | output | 1 | System clock enable |
| clkout_en_o | output | 1 | Clock-out pin enable (low parks the pin low) |
| osc_tmo_err_o | output | 1 | Oscillator startup timeout flag |

## Verification
A wrong state shows at the ports on the very next edge, because every enable is a registered decode of the next state. A state reached too early shows up as sys_clk_en_o or flash_clk_en_o rising while a wait input is still low. A pre-roll counter that is off by one moves the sys_clk_en_o rise by a cycle against the flash enable. A bad skip decision shows up as pll_en_o or osc_en_o out of step with the configured stop bits, within one cycle of the wakeup. A timeout counter error moves osc_tmo_err_o by at least one cycle relative to the programmed limit.

// File: rtl/stop_seq_pkg.sv
package stop_seq_pkg;
  localparam int CFG_W = 5;

  typedef enum logic [2:0] {
    ST_RUN, ST_ENTER, ST_STOP, ST_OSC_WAIT, ST_LOCK_WAIT, ST_PREROLL
  } seq_state_e;

  // field order fixes the write-data bit positions: bit0 osc_off .. bit4 ext_clk
  typedef struct packed {
    logic ext_clk;
    logic skip_lock;
    logic clkout_off;
    logic pll_off;
    logic osc_off;
  } seq_cfg_t;

  typedef struct packed {
    logic osc;
    logic pll;
    logic flash;
    logic sys;
    logic clkout;
  } clk_en_t;

  localparam seq_cfg_t CFG_RESET = '{ext_clk: 1'b0, skip_lock: 1'b0, clkout_off: 1'b0,
                                     pll_off: 1'b1, osc_off: 1'b1};
endpackage

// File: rtl/seq_counter.sv
module seq_counter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/stop_seq_regs.sv
module stop_seq_regs
  import stop_seq_pkg::*;
#(
  parameter int           TMO_W   = 8,
  parameter logic [TMO_W-1:0] TMO_RST = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             tmo_we_i,
  input  logic [TMO_W-1:0] tmo_wdata_i,
  output seq_cfg_t         cfg_o,
  output logic [TMO_W-1:0] tmo_o
);
  seq_cfg_t         cfg_q;
  logic [TMO_W-1:0] tmo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= CFG_RESET;
    else if (cfg_we_i) cfg_q <= seq_cfg_t'(cfg_wdata_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tmo_q <= TMO_RST;
    else if (tmo_we_i) tmo_q <= tmo_wdata_i;
  end

  assign cfg_o = cfg_q;
  assign tmo_o = tmo_q;
endmodule

// File: rtl/stop_seq_fsm.sv
module stop_seq_fsm
  import stop_seq_pkg::*;
#(
  parameter int TMO_W   = 8,
  parameter int PRE_CYC = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  seq_cfg_t         cfg_i,
  input  logic [TMO_W-1:0] tmo_i,
  input  logic             stop_req_i,
  input  logic             wake_i,
  input  logic             osc_ready_i,
  input  logic             pll_lock_i,
  output clk_en_t          en_o,
  output logic             err_o
);
  localparam int PRE_W = $clog2(PRE_CYC + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_CYC - 1);

  seq_state_e       state_q, state_d;
  clk_en_t          en_q;
  logic             err_q, err_d;
  logic [PRE_W-1:0] pre_cnt;
  logic [TMO_W-1:0] tmo_cnt;
  logic             in_osc_wait, in_preroll;

  assign in_osc_wait = (state_q == ST_OSC_WAIT);
  assign in_preroll  = (state_q == ST_PREROLL);

  seq_counter #(.W(PRE_W)) u_pre_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (!in_preroll),
    .inc_i (in_preroll),
    .cnt_o (pre_cnt)
  );

  // saturates at the programmed limit
  seq_counter #(.W(TMO_W)) u_tmo_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (!in_osc_wait),
    .inc_i (in_osc_wait && (tmo_cnt != tmo_i)),
    .cnt_o (tmo_cnt)
  );

  function automatic logic need_lock(seq_cfg_t c);
    return c.pll_off && !c.skip_lock && !c.ext_clk;
  endfunction

  function automatic seq_state_e wake_target(seq_cfg_t c);
    if (c.ext_clk)      return ST_PREROLL;
    else if (c.osc_off) return ST_OSC_WAIT;
    else if (need_lock(c)) return ST_LOCK_WAIT;
    else                return ST_PREROLL;
  endfunction

  function automatic clk_en_t decode(seq_state_e s, seq_cfg_t c);
    clk_en_t e;
    e = '0;
    unique case (s)
      ST_RUN:       begin e.osc = 1'b1; e.pll = 1'b1; e.flash = 1'b1; e.sys = 1'b1; end
      ST_ENTER:     begin e.osc = 1'b1; e.pll = 1'b1; end
      ST_STOP:      begin e.osc = !c.osc_off; e.pll = !c.pll_off; end
      ST_OSC_WAIT:  begin e.osc = 1'b1; e.pll = !c.pll_off; end
      ST_LOCK_WAIT: begin e.osc = 1'b1; e.pll = 1'b1; end
      ST_PREROLL:   begin e.osc = 1'b1; e.pll = 1'b1; e.flash = 1'b1; end
      default:      e = '0;
    endcase
    e.clkout = e.pll && !c.clkout_off;
    return e;
  endfunction

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:       if (stop_req_i && !wake_i) state_d = ST_ENTER;
      ST_ENTER:     state_d = wake_i ? ST_PREROLL : ST_STOP;
      ST_STOP:      if (wake_i) state_d = wake_target(cfg_i);
      ST_OSC_WAIT: begin
        if (cfg_i.ext_clk)    state_d = ST_PREROLL;
        else if (osc_ready_i) state_d = need_lock(cfg_i) ? ST_LOCK_WAIT : ST_PREROLL;
      end
      ST_LOCK_WAIT: if (pll_lock_i || !need_lock(cfg_i)) state_d = ST_PREROLL;
      ST_PREROLL:   if (pre_cnt == PRE_LAST) state_d = ST_RUN;
      default:      state_d = ST_RUN;
    endcase
  end

  always_comb begin
    err_d = 1'b0;
    if (in_osc_wait && !osc_ready_i && !cfg_i.ext_clk)
      err_d = err_q || (tmo_cnt == tmo_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      en_q    <= '1;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      en_q    <= decode(state_d, cfg_i);
      err_q   <= err_d;
    end
  end

  assign en_o  = en_q;
  assign err_o = err_q;
endmodule

// File: rtl/stop_clk_seq.sv
module stop_clk_seq
  import stop_seq_pkg::*;
#(
  parameter int               TMO_W   = 8,
  parameter logic [TMO_W-1:0] TMO_RST = 8'd200,
  parameter int               PRE_CYC = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [4:0]       cfg_wdata_i,
  input  logic             tmo_we_i,
  input  logic [TMO_W-1:0] tmo_wdata_i,
  input  logic             stop_req_i,
  input  logic             irq_wake_i,
  input  logic             dbg_wake_i,
  input  logic             osc_ready_i,
  input  logic             pll_lock_i,
  output logic             osc_en_o,
  output logic             pll_en_o,
  output logic             flash_clk_en_o,
  output logic             sys_clk_en_o,
  output logic             clkout_en_o,
  output logic             osc_tmo_err_o
);
  seq_cfg_t         cfg;
  logic [TMO_W-1:0] tmo;
  clk_en_t          en;

  stop_seq_regs #(.TMO_W(TMO_W), .TMO_RST(TMO_RST)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we_i),
    .cfg_wdata_i(cfg_wdata_i),
    .tmo_we_i   (tmo_we_i),
    .tmo_wdata_i(tmo_wdata_i),
    .cfg_o      (cfg),
    .tmo_o      (tmo)
  );

  stop_seq_fsm #(.TMO_W(TMO_W), .PRE_CYC(PRE_CYC)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_i      (cfg),
    .tmo_i      (tmo),
    .stop_req_i (stop_req_i),
    .wake_i     (irq_wake_i || dbg_wake_i),
    .osc_ready_i(osc_ready_i),
    .pll_lock_i (pll_lock_i),
    .en_o       (en),
    .err_o      (osc_tmo_err_o)
  );

  assign osc_en_o       = en.osc;
  assign pll_en_o       = en.pll;
  assign flash_clk_en_o = en.flash;
  assign sys_clk_en_o   = en.sys;
  assign clkout_en_o    = en.clkout;
endmodule

// File: rtl/stop_clk_seq_chk.sv
module stop_clk_seq_chk #(
  parameter int PRE_CYC = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic stop_req_i,
  input logic irq_wake_i,
  input logic dbg_wake_i,
  input logic osc_en_o,
  input logic pll_en_o,
  input logic flash_clk_en_o,
  input logic sys_clk_en_o,
  input logic clkout_en_o,
  input logic osc_tmo_err_o
);
  int unsigned pre_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_len <= 0;
    else if (flash_clk_en_o && !sys_clk_en_o) pre_len <= pre_len + 1;
    else pre_len <= 0;
  end

  a_r7_preroll_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_clk_en_o) |-> (pre_len == PRE_CYC));

  a_r7_sys_needs_flash: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_clk_en_o |-> (flash_clk_en_o && osc_en_o && pll_en_o));

  a_r9_clkout_needs_pll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clkout_en_o |-> pll_en_o);

  a_r2_stop_gates_sys: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_clk_en_o && stop_req_i && !irq_wake_i && !dbg_wake_i) |=> !sys_clk_en_o);

  a_r12_run_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_clk_en_o && !stop_req_i) |=> sys_clk_en_o);

  a_r13_err_in_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_tmo_err_o |-> (osc_en_o && !sys_clk_en_o && !flash_clk_en_o));
endmodule

bind stop_clk_seq stop_clk_seq_chk #(.PRE_CYC(PRE_CYC)) u_chk (.*);

// File: tb/tb_stop_clk_seq.sv
module tb_stop_clk_seq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [4:0] cfg_wdata_i = '0;
  logic       tmo_we_i = 1'b0;
  logic [7:0] tmo_wdata_i = '0;
  logic       stop_req_i = 1'b0, irq_wake_i = 1'b0, dbg_wake_i = 1'b0;
  logic       osc_ready_i = 1'b0, pll_lock_i = 1'b0;
  logic       osc_en_o, pll_en_o, flash_clk_en_o, sys_clk_en_o, clkout_en_o, osc_tmo_err_o;

  stop_clk_seq dut (.*);

  always #5 clk_i = ~clk_i;

  // {osc, pll, flash, sys, clkout, err}
  localparam logic [5:0] V_RUN    = 6'b111110;
  localparam logic [5:0] V_ENTER  = 6'b110010;
  localparam logic [5:0] V_STOP0  = 6'b000000;
  localparam logic [5:0] V_STOP1  = 6'b110010;
  localparam logic [5:0] V_OSCW   = 6'b100000;
  localparam logic [5:0] V_OSCERR = 6'b100001;
  localparam logic [5:0] V_LOCKW  = 6'b110010;
  localparam logic [5:0] V_PRE    = 6'b111010;

  int cyc = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int    q_due[$];
  logic [5:0] q_val[$];
  string q_tag[$];

  wire [5:0] obs = {osc_en_o, pll_en_o, flash_clk_en_o, sys_clk_en_o, clkout_en_o, osc_tmo_err_o};

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic expect_in(int d, logic [5:0] v, string tag);
    q_due.push_back(cyc + d);
    q_val.push_back(v);
    q_tag.push_back(tag);
  endtask

  task automatic chk_now(logic [5:0] v, string tag);
    n_chk++;
    if (obs !== v) begin
      n_fail++;
      $display("FAIL %s cyc=%0d actual=%b expected=%b", tag, cyc, obs, v);
    end
  endtask

  // monitor: compare scoreboard items as they fall due
  always @(negedge clk_i) begin
    while (q_due.size() > 0 && q_due[0] <= cyc) begin
      void'(q_due.pop_front());
      chk_now(q_val.pop_front(), q_tag.pop_front());
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr_cfg(logic [4:0] v);
    cfg_wdata_i = v; cfg_we_i = 1'b1;
    step(1);
    cfg_we_i = 1'b0;
    step(3);
  endtask

  task automatic wr_tmo(logic [7:0] v);
    tmo_wdata_i = v; tmo_we_i = 1'b1;
    step(1);
    tmo_we_i = 1'b0;
    step(3);
  endtask

  task automatic enter_stop(logic [5:0] stop_val, string tag);
    stop_req_i = 1'b1;
    expect_in(1, (stop_val == V_STOP0 && tag == "R10") ? 6'b110000 : V_ENTER, "R2 entry");
    step(1);
    stop_req_i = 1'b0;
    expect_in(1, stop_val, tag);
    step(3);
  endtask

  task automatic pulse_irq();
    irq_wake_i = 1'b1;
    step(1);
    irq_wake_i = 1'b0;
  endtask

  task automatic settle();
    osc_ready_i = 1'b0; pll_lock_i = 1'b0;
    step(4);
  endtask

  initial begin
    step(2);
    chk_now(V_RUN, "R1 in reset");
    rst_ni = 1'b1;
    step(2);
    chk_now(V_RUN, "R1 after reset");

    // default cfg: osc/pll off in stop, full wait chain
    enter_stop(V_STOP0, "R2 stop state, R9 clkout low");
    irq_wake_i = 1'b1;
    expect_in(1, V_OSCW, "R3 osc wait");
    step(1);
    irq_wake_i = 1'b0;
    expect_in(2, V_OSCW, "R3 holds");
    step(3);
    osc_ready_i = 1'b1;
    expect_in(1, V_LOCKW, "R4 lock wait");
    expect_in(3, V_LOCKW, "R4 holds");
    step(4);
    pll_lock_i = 1'b1;
    expect_in(1, V_PRE, "R7 preroll start");
    expect_in(16, V_PRE, "R7 preroll last");
    expect_in(17, V_RUN, "R7 sys on");
    step(20);
    settle();

    // osc and pll kept running
    wr_cfg(5'b00000);
    enter_stop(V_STOP1, "R8 stop sources on");
    irq_wake_i = 1'b1;
    expect_in(1, V_PRE, "R8 no waits");
    expect_in(17, V_RUN, "R8 run");
    step(1);
    irq_wake_i = 1'b0;
    step(20);

    // debug wake, stop request during wakeup ignored
    enter_stop(V_STOP1, "R8 stop");
    dbg_wake_i = 1'b1;
    expect_in(1, V_PRE, "R12 dbg wake");
    expect_in(17, V_RUN, "R12 stop ignored in preroll");
    expect_in(19, V_RUN, "R12 still run");
    step(1);
    dbg_wake_i = 1'b0;
    step(2);
    stop_req_i = 1'b1;
    step(1);
    stop_req_i = 1'b0;
    step(20);
    stop_req_i = 1'b1; irq_wake_i = 1'b1;
    expect_in(1, V_RUN, "R12 stop with wake ignored");
    step(1);
    stop_req_i = 1'b0; irq_wake_i = 1'b0;
    step(3);

    // lock bypass
    wr_cfg(5'b01011);
    enter_stop(V_STOP0, "R2 stop");
    pulse_irq();
    step(2);
    osc_ready_i = 1'b1;
    expect_in(1, V_PRE, "R5 skip lock");
    expect_in(17, V_RUN, "R5 run");
    step(20);
    settle();

    // external clock mode
    wr_cfg(5'b10011);
    enter_stop(V_STOP0, "R2 stop");
    irq_wake_i = 1'b1;
    expect_in(1, V_PRE, "R6 ext no waits");
    expect_in(17, V_RUN, "R6 run");
    step(1);
    irq_wake_i = 1'b0;
    step(20);

    // wake during entry cycle
    wr_cfg(5'b00011);
    stop_req_i = 1'b1;
    expect_in(1, V_ENTER, "R11 entry");
    step(1);
    stop_req_i = 1'b0; irq_wake_i = 1'b1;
    expect_in(1, V_PRE, "R11 abort to preroll");
    expect_in(16, V_PRE, "R11 preroll last");
    expect_in(17, V_RUN, "R11 run");
    step(1);
    irq_wake_i = 1'b0;
    step(20);

    // clock-out disabled
    wr_cfg(5'b00111);
    chk_now(6'b111100, "R10 run clkout low");
    enter_stop(V_STOP0, "R10");
    pulse_irq();
    osc_ready_i = 1'b1;
    expect_in(1, 6'b110000, "R10 lock wait clkout low");
    step(2);
    pll_lock_i = 1'b1;
    expect_in(1, 6'b111000, "R10 preroll clkout low");
    expect_in(17, 6'b111100, "R10 run clkout low");
    step(20);
    settle();

    // oscillator timeout
    wr_cfg(5'b00011);
    wr_tmo(8'd4);
    enter_stop(V_STOP0, "R2 stop");
    irq_wake_i = 1'b1;
    expect_in(5, V_OSCW, "R13 no err yet");
    expect_in(6, V_OSCERR, "R13 err raised");
    expect_in(9, V_OSCERR, "R13 err held");
    step(1);
    irq_wake_i = 1'b0;
    step(8);
    osc_ready_i = 1'b1;
    expect_in(1, V_LOCKW, "R13 err cleared");
    step(2);
    pll_lock_i = 1'b1;
    expect_in(17, V_RUN, "R13 run");
    step(20);
    settle();

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule